// File: doc/BRIEF.md
# Shared Timer/Watchdog Prescaler

This block holds one power-of-two prescaler that serves either an 8-bit event timer or a watchdog, never both at once. The timer takes its events from the instruction clock or from an external pin. The pin is synchronised into the instruction-clock domain, and either its rising or its falling edges are counted. The watchdog takes single-cycle ticks from its own oscillator, which are already aligned to the instruction clock. When it has seen a set number of post-scaled ticks it raises a reset request. The consumer that does not own the prescaler is fed directly, with no division.

Reassignment is managed by a three-state machine:
- `ASG_WDT`: the prescaler drives the watchdog.
- `ASG_TMR`: the prescaler drives the timer.
- `ASG_SETTLE`: a one-cycle quiet state.

Transitions:
- Any change of the assignment bit or of the rate bits moves the machine from `ASG_WDT` or `ASG_TMR` to `ASG_SETTLE`.
- When the configuration is steady, `ASG_SETTLE` leaves for `ASG_WDT` (assignment bit set) or for `ASG_TMR` (assignment bit clear).
- `ASG_SETTLE` stays put if the configuration changes again.

While in `ASG_SETTLE`, the prescaler is held clear and its output goes to nobody. Flipping the assignment back and forth therefore cannot produce a false clock pulse, even at a 1:1 watchdog rate.

Top module: `tmr_wdt_prescaler`

## Requirements
- R1: After reset the machine is in `ASG_WDT`, `tmr_value` is 0, and `tmr_ovf` and `wdt_reset` are 0.
- R2: With `psa_wdt`=1 the timer bypasses the prescaler. It advances once per instruction clock when `src_ext`=0, or once per selected pin edge when `src_ext`=1.
- R3: With `psa_wdt`=0 the timer advances once every 2^(`rate`+1) source events, so `rate`=0..7 gives 2..256.
- R4: The pin passes through a two-flop synchroniser. `edge_fall`=1 counts falling edges and `edge_fall`=0 counts rising edges.
- R5: Changing `edge_fall` while the pin is steady produces no timer count.
- R6: The watchdog issues a one-cycle `wdt_reset` pulse on its WDT_LIMIT-th post-scaled tick (default 16) and then restarts from zero. With `psa_wdt`=0 every `wdt_tick` counts directly.
- R7: With `psa_wdt`=1 the watchdog sees one tick per 2^`rate` oscillator ticks. `rate`=0 is a 1:1 bypass.
- R8: `wdt_clear` zeroes the watchdog count, and also the prescaler when the prescaler belongs to the watchdog.
- R9: Any change of `psa_wdt` or `rate` passes through one `ASG_SETTLE` cycle. In that cycle the prescaler is cleared and sends no pulse to either consumer, so reassignment never causes a watchdog count.
- R10: `tmr_ovf` is a one-cycle pulse when the timer wraps from 255 to 0, and `tmr_value` reads 0 during that pulse.
- R11: A rate change clears the prescaler. The first prescaled event after the change therefore needs a full new period of source events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst_n | input | 1 | Active-low reset |
| wdt_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| ext_pin | input | 1 | External timer clock pin (asynchronous) |
| src_ext | input | 1 | 1: timer counts pin edges, 0: instruction clocks |
| edge_fall | input | 1 | 1: falling pin edges, 0: rising |
| psa_wdt | input | 1 | 1: prescaler owned by watchdog, 0: by timer |
| rate | input | 3 | Prescale rate selector |
| wdt_clear | input | 1 | Watchdog clear strobe |
| tmr_value | output | 8 | Current timer count |
| tmr_ovf | output | 1 | Timer wrap pulse |
| wdt_reset | output | 1 | Watchdog time-out reset request |

## Verification
The assertions assume the following about the inputs:
- `wdt_tick` and `wdt_clear` are synchronous single-cycle strobes.
- The configuration inputs change only between clock edges.
- WDT_LIMIT is at least 2.

The stimulus drives every input at the falling edge and spaces watchdog ticks two cycles apart. Before any count is measured, it waits out the settle cycle and the synchroniser latency. Expected timer and watchdog counts come from the power-of-two rate formulas, which are swept over all eight rate codes.

// File: rtl/tps_pkg.sv
package tps_pkg;
    typedef enum logic [1:0] {
        ASG_WDT    = 2'd0,
        ASG_TMR    = 2'd1,
        ASG_SETTLE = 2'd2
    } asg_state_e;
endpackage

// File: rtl/tps_sync_edge.sv
module tps_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Both samples use the current polarity, so flipping fall_sel alone
    // cannot manufacture an edge.
    always_comb begin
        edge_pulse = (sync_q[STAGES-1] ^ fall_sel) & ~(prev_q ^ fall_sel);
    end

    assert_edge_needs_pin_change_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        edge_pulse |-> (sync_q[STAGES-1] != prev_q));
endmodule

// File: rtl/tps_assign_fsm.sv
module tps_assign_fsm #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psa_wdt,
    input  logic [RATE_W-1:0] rate,
    input  logic              wdt_clear,
    output logic              presc_clr,
    output logic              to_wdt,
    output logic              to_tmr
);
    import tps_pkg::*;

    asg_state_e        state_q, state_d;
    logic              psa_q;
    logic [RATE_W-1:0] rate_q;
    logic              cfg_change;

    always_comb begin
        cfg_change = (psa_wdt != psa_q) || (rate != rate_q);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ASG_WDT:    if (cfg_change) state_d = ASG_SETTLE;
            ASG_TMR:    if (cfg_change) state_d = ASG_SETTLE;
            ASG_SETTLE: if (!cfg_change) state_d = psa_wdt ? ASG_WDT : ASG_TMR;
            default:    state_d = ASG_SETTLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ASG_WDT;
            psa_q   <= 1'b1;
            rate_q  <= '0;
        end else begin
            state_q <= state_d;
            psa_q   <= psa_wdt;
            rate_q  <= rate;
        end
    end

    always_comb begin
        presc_clr = cfg_change;
        to_wdt    = 1'b0;
        to_tmr    = 1'b0;
        unique case (state_q)
            ASG_WDT: begin
                to_wdt = !cfg_change;
                if (wdt_clear) presc_clr = 1'b1;
            end
            ASG_TMR: begin
                to_tmr = !cfg_change;
            end
            ASG_SETTLE: begin
                presc_clr = 1'b1;
            end
            default: begin
                presc_clr = 1'b1;
            end
        endcase
    end

    assert_change_settles_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        cfg_change |=> (state_q == ASG_SETTLE));

    assert_settle_no_owner_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ASG_SETTLE) |-> (!to_wdt && !to_tmr));
endmodule

// File: rtl/tps_prescaler.sv
module tps_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] mask,
    output logic         out
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        out = tick && !clr && ((cnt_q & mask) == mask);
    end

    assert_clear_empties_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/tps_watchdog.sv
module tps_watchdog #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic reset_req
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            reset_req <= 1'b0;
        end else if (clr) begin
            cnt_q     <= '0;
            reset_req <= 1'b0;
        end else if (inc) begin
            if (cnt_q == LAST) begin
                cnt_q     <= '0;
                reset_req <= 1'b1;
            end else begin
                cnt_q     <= cnt_q + 1'b1;
                reset_req <= 1'b0;
            end
        end else begin
            reset_req <= 1'b0;
        end
    end

    assert_reset_single_cycle_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    assert_clear_restarts_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !reset_req));
endmodule

// File: rtl/tps_timer.sv
module tps_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         ovf
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= inc && (value == '1);
            if (inc) value <= value + 1'b1;
        end
    end

    assert_wrap_reads_zero_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        ovf |-> (value == '0));
endmodule

// File: rtl/tmr_wdt_prescaler.sv
module tmr_wdt_prescaler #(
    parameter int PS_W        = 8,
    parameter int RATE_W      = 3,
    parameter int TMR_W       = 8,
    parameter int WDT_LIMIT   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdt_tick,
    input  logic              ext_pin,
    input  logic              src_ext,
    input  logic              edge_fall,
    input  logic              psa_wdt,
    input  logic [RATE_W-1:0] rate,
    input  logic              wdt_clear,
    output logic [TMR_W-1:0]  tmr_value,
    output logic              tmr_ovf,
    output logic              wdt_reset
);
    logic [PS_W:0]   tmr_div, wdt_div;
    logic [PS_W-1:0] ps_mask;
    logic            pin_edge, tmr_src, ps_tick, ps_out;
    logic            presc_clr, to_wdt, to_tmr;
    logic            tmr_inc, wdt_inc;

    tps_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin),
        .fall_sel(edge_fall), .edge_pulse(pin_edge)
    );

    tps_assign_fsm #(.RATE_W(RATE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .psa_wdt(psa_wdt), .rate(rate),
        .wdt_clear(wdt_clear), .presc_clr(presc_clr),
        .to_wdt(to_wdt), .to_tmr(to_tmr)
    );

    always_comb begin
        tmr_div = (PS_W+1)'(2) << rate;
        wdt_div = (PS_W+1)'(1) << rate;
        ps_mask = psa_wdt ? PS_W'(wdt_div - 1'b1) : PS_W'(tmr_div - 1'b1);
        tmr_src = src_ext ? pin_edge : 1'b1;
        ps_tick = psa_wdt ? wdt_tick : tmr_src;
    end

    tps_prescaler #(.W(PS_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .clr(presc_clr), .tick(ps_tick),
        .mask(ps_mask), .out(ps_out)
    );

    always_comb begin
        if (to_tmr)       tmr_inc = ps_out;
        else if (psa_wdt) tmr_inc = tmr_src;
        else              tmr_inc = 1'b0;

        if (to_wdt)        wdt_inc = (rate == '0) ? wdt_tick : ps_out;
        else if (!psa_wdt) wdt_inc = wdt_tick;
        else               wdt_inc = 1'b0;
    end

    tps_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .inc(tmr_inc),
        .value(tmr_value), .ovf(tmr_ovf)
    );

    tps_watchdog #(.LIMIT(WDT_LIMIT)) u_wdt (
        .clk(clk), .rst_n(rst_n), .clr(wdt_clear), .inc(wdt_inc),
        .reset_req(wdt_reset)
    );

    assert_owner_exclusive_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(to_wdt && to_tmr));
endmodule

// File: tb/sim_tmr_wdt_prescaler.sv
module sim_tmr_wdt_prescaler;
    localparam int LIMIT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_tick = 1'b0, ext_pin = 1'b0, src_ext = 1'b0, edge_fall = 1'b0;
    logic       psa_wdt = 1'b1, wdt_clear = 1'b0;
    logic [2:0] rate = 3'd0;
    logic [7:0] tmr_value;
    logic       tmr_ovf, wdt_reset;

    int checks = 0, errors = 0, rst_seen = 0, ovf_seen = 0, ovf_bad = 0;

    always #4 clk = ~clk;

    tmr_wdt_prescaler u0 (
        .clk(clk), .rst_n(rst_n), .wdt_tick(wdt_tick), .ext_pin(ext_pin),
        .src_ext(src_ext), .edge_fall(edge_fall), .psa_wdt(psa_wdt),
        .rate(rate), .wdt_clear(wdt_clear), .tmr_value(tmr_value),
        .tmr_ovf(tmr_ovf), .wdt_reset(wdt_reset)
    );

    always @(negedge clk) begin
        if (rst_n && wdt_reset) rst_seen++;
        if (rst_n && tmr_ovf) begin
            ovf_seen++;
            if (tmr_value != 8'd0) ovf_bad++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            wdt_tick = 1'b1; cyc(1);
            wdt_tick = 1'b0; cyc(1);
        end
    endtask

    task automatic clear_wdt();
        wdt_clear = 1'b1; cyc(1);
        wdt_clear = 1'b0; cyc(2);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1600000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [7:0] v0;
        int r0;
        cyc(3);
        // R1: reset state
        check(tmr_value == 0, "R1 tmr_value", tmr_value, 0);
        check(!tmr_ovf && !wdt_reset, "R1 flags", {tmr_ovf, wdt_reset}, 0);
        rst_n = 1'b1;
        // R1: starts watchdog-owned, so rate 0 and psa 1 give direct timer counts
        v0 = tmr_value; cyc(40);
        check(8'(tmr_value - v0) == 40, "R1/R2 internal bypass", 8'(tmr_value - v0), 40);

        // R10: wrap pulses
        r0 = ovf_seen; cyc(512);
        check(ovf_seen - r0 == 2, "R10 wrap count", ovf_seen - r0, 2);
        check(ovf_bad == 0, "R10 value zero at wrap", ovf_bad, 0);

        // R3: timer prescaled, all rates
        psa_wdt = 1'b0;
        for (int r = 0; r < 8; r++) begin
            rate = 3'(r); cyc(4);
            v0 = tmr_value; cyc(3 * (2 << r));
            check(8'(tmr_value - v0) == 3, $sformatf("R3 rate %0d", r), 8'(tmr_value - v0), 3);
        end

        // R11: rate change clears prescaler
        rate = 3'd7; cyc(4); cyc(200);
        v0 = tmr_value; rate = 3'd6; cyc(120);
        check(8'(tmr_value - v0) == 0, "R11 no early output", 8'(tmr_value - v0), 0);
        cyc(20);
        check(8'(tmr_value - v0) == 1, "R11 full period", 8'(tmr_value - v0), 1);

        // R4/R2: external pin, direct
        psa_wdt = 1'b1; rate = 3'd0; src_ext = 1'b1; ext_pin = 1'b0; edge_fall = 1'b0; cyc(6);
        v0 = tmr_value; ext_pin = 1'b1; cyc(5);
        check(8'(tmr_value - v0) == 1, "R4 rising counted", 8'(tmr_value - v0), 1);
        ext_pin = 1'b0; cyc(5);
        check(8'(tmr_value - v0) == 1, "R4 falling ignored", 8'(tmr_value - v0), 1);
        edge_fall = 1'b1; cyc(5);
        v0 = tmr_value; ext_pin = 1'b1; cyc(5);
        check(8'(tmr_value - v0) == 0, "R4 rising ignored", 8'(tmr_value - v0), 0);
        ext_pin = 1'b0; cyc(5);
        check(8'(tmr_value - v0) == 1, "R4 falling counted", 8'(tmr_value - v0), 1);
        v0 = tmr_value;
        for (int i = 0; i < 6; i++) begin
            ext_pin = 1'b1; cyc(4); ext_pin = 1'b0; cyc(4);
        end
        cyc(4);
        check(8'(tmr_value - v0) == 6, "R2 pin edges direct", 8'(tmr_value - v0), 6);

        // R5: polarity flips with steady pin
        ext_pin = 1'b1; cyc(6); v0 = tmr_value;
        for (int i = 0; i < 4; i++) begin
            edge_fall = ~edge_fall; cyc(3);
        end
        cyc(3);
        check(8'(tmr_value - v0) == 0, "R5 no count on polarity flip", 8'(tmr_value - v0), 0);

        // R3 with pin source: divide by 4, 8 rising edges
        edge_fall = 1'b0; ext_pin = 1'b0; psa_wdt = 1'b0; rate = 3'd1; cyc(6);
        v0 = tmr_value;
        for (int i = 0; i < 8; i++) begin
            ext_pin = 1'b1; cyc(4); ext_pin = 1'b0; cyc(4);
        end
        cyc(4);
        check(8'(tmr_value - v0) == 2, "R3 pin prescaled", 8'(tmr_value - v0), 2);

        // R6: watchdog direct while timer owns prescaler
        src_ext = 1'b0; cyc(3); clear_wdt();
        r0 = rst_seen; ticks(LIMIT - 1); cyc(3);
        check(rst_seen == r0, "R6 no early timeout", rst_seen - r0, 0);
        ticks(1); cyc(3);
        check(rst_seen == r0 + 1, "R6 timeout", rst_seen - r0, 1);

        // R7: watchdog prescaled, all rates
        psa_wdt = 1'b1;
        for (int r = 0; r < 8; r++) begin
            rate = 3'(r); cyc(3); clear_wdt();
            r0 = rst_seen; ticks(LIMIT * (1 << r) - 1); cyc(3);
            check(rst_seen == r0, $sformatf("R7 rate %0d early", r), rst_seen - r0, 0);
            ticks(1); cyc(3);
            check(rst_seen == r0 + 1, $sformatf("R7 rate %0d timeout", r), rst_seen - r0, 1);
        end

        // R8: clear mid-count
        rate = 3'd2; cyc(3); clear_wdt();
        r0 = rst_seen; ticks(40); clear_wdt(); ticks(LIMIT * 4 - 1); cyc(3);
        check(rst_seen == r0, "R8 clear restarts", rst_seen - r0, 0);
        ticks(1); cyc(3);
        check(rst_seen == r0 + 1, "R8 timeout after clear", rst_seen - r0, 1);

        // R9: reassignment with pin at idle level of selected edge, 1:1 rate
        src_ext = 1'b1; ext_pin = 1'b1; edge_fall = 1'b1; rate = 3'd0; cyc(6);
        clear_wdt(); r0 = rst_seen; ticks(LIMIT - 1); v0 = tmr_value;
        for (int i = 0; i < 4; i++) begin
            psa_wdt = 1'b0; cyc(3); psa_wdt = 1'b1; cyc(3);
        end
        check(rst_seen == r0, "R9 no spurious reset", rst_seen - r0, 0);
        check(8'(tmr_value - v0) == 0, "R9 no spurious timer count", 8'(tmr_value - v0), 0);
        ticks(1); cyc(3);
        check(rst_seen == r0 + 1, "R9 genuine tick times out", rst_seen - r0, 1);

        finish_run();
    end
endmodule